// File: doc/BRIEF.md
# Configurable Aspect-Ratio Dual-Port RAM

This block is a behavioural model of a 36 Kbit on-chip memory with two ports. Each port sees the same storage through its own word width, chosen at build time from 1, 2, 4, 9, 18, 36 or 72 bits. The depth scales to match. Narrow shapes (1, 2, 4) address only the 32 Kbit data portion. Shapes of 9 bits and wider also expose the 4 Kbit of parity storage, with one extra bit per byte.

Two operating modes exist. In the general mode both ports can read and write. In the split mode, port A is a write-only port and port B is a read-only port, and only this mode allows the 72-bit shape. Reads are registered, so data appears one cycle after the request. A port that writes returns the previous contents of the word it wrote. Both ports share one clock.

Top module: `arp_dual_ram`

## Requirements
- R1: While rst_ni is low, and after it rises until the first enabled read, both read outputs are all zeros.
- R2: The legal widths are 1, 2, 4, 9, 18, 36 and 72. The depth is 32768/w for w of 4 or less, and 36864/w for w of 9 or more. With enable high, the addressed word appears on the read output after the next rising clock edge.
- R3: With enable low, a port writes nothing, and its read output holds its last value even if write enable is high.
- R4: A port that writes returns on its read output the contents of the addressed word from before that write.
- R5: When one port writes a word that the other port reads in the same cycle, the reader returns the contents from before the write.
- R6: Storage is 512 rows of eight 9-bit groups. Each group holds data in bits [7:0] and parity in bit 8. A word of width w of 9 or more at address a sits in row a/(72/w), starting at bit (a mod (72/w))*w of the row. A word of width w of 4 or less uses only the 64 data bits of row a/(64/w), starting at data bit (a mod (64/w))*w. Data bits are counted group by group and skip parity. A narrow port never changes a parity bit.
- R7: When both ports write the same bit in one cycle, that bit's stored value is undefined. Every other bit written by either port takes its written value.
- R8: In split mode, port A only writes and its read output stays zero. Port B only reads, and its write enable has no effect on storage.
- R9: In split mode, a 72-bit write on port A stores a full row in one access. A 9-bit port B reads back group k of row r at address 8r+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | A_AW | Port A word address |
| a_wdata_i | input | A_WIDTH | Port A write data |
| a_rdata_o | output | A_WIDTH | Port A registered read data |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | 1 | Port B write enable (ignored in split mode) |
| b_addr_i | input | B_AW | Port B word address |
| b_wdata_i | input | B_WIDTH | Port B write data |
| b_rdata_o | output | B_WIDTH | Port B registered read data |

## Verification
Two operations can land on the same row in one cycle. The first is a narrow write on one port while the wider port reads or writes the word that contains that slice. The bench provokes the read case by having the 4-bit port write a nibble while the 18-bit port reads the enclosing word. That read must return the old word, and a follow-up read must show the merged result. The bench provokes the write case by having both ports write overlapping bits. It works out the overlap from the address mapping and reports it as a collision. It then checks only the bits outside the overlap, and accepts either writer's value for the shared bits.

// File: rtl/arp_pkg.sv
`timescale 1ns/1ps
package arp_pkg;
  localparam int ROWS      = 512;
  localparam int GROUPS    = 8;
  localparam int GROUP_W   = 9;
  localparam int GDATA_W   = 8;
  localparam int ROW_W     = GROUPS * GROUP_W;
  localparam int ROW_DATA  = GROUPS * GDATA_W;
  localparam int ROW_AW    = $clog2(ROWS);
  localparam int POS_W     = $clog2(ROW_W);

  function automatic bit width_ok(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) ||
           (w == 18) || (w == 36) || (w == 72);
  endfunction

  function automatic int per_row(int w);
    return (w < GROUP_W) ? ROW_DATA / w : ROW_W / w;
  endfunction

  function automatic int depth_of(int w);
    return ROWS * per_row(w);
  endfunction

  // row bit that holds bit j of slot s for width w
  function automatic int phys_pos(int w, int s, int j);
    int idx;
    idx = s * w + j;
    if (w < GROUP_W) return (idx / GDATA_W) * GROUP_W + (idx % GDATA_W);
    return idx;
  endfunction

  function automatic logic [ROW_W-1:0] par_mask();
    logic [ROW_W-1:0] m;
    m = '0;
    for (int g = 0; g < GROUPS; g++) m[g*GROUP_W + GDATA_W] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/arp_port_map.sv
`timescale 1ns/1ps
module arp_port_map #(
  parameter int WIDTH = 9,
  parameter int AW    = $clog2(arp_pkg::depth_of(WIDTH))
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  input  logic [arp_pkg::ROW_W-1:0]   rrow_i,
  output logic [arp_pkg::ROW_AW-1:0]  row_o,
  output logic [arp_pkg::ROW_W-1:0]   wmask_o,
  output logic [arp_pkg::ROW_W-1:0]   wrow_o,
  output logic [WIDTH-1:0]            rdata_o
);
  localparam int PER_ROW = arp_pkg::per_row(WIDTH);
  localparam int LOG_PR  = $clog2(PER_ROW);
  localparam int PW      = arp_pkg::POS_W;
  localparam int RAW     = arp_pkg::ROW_AW;

  logic [AW-1:0] slot_d, slot_q;

  assign slot_d = addr_i & AW'(PER_ROW - 1);
  assign row_o  = RAW'(addr_i >> LOG_PR);

  always_comb begin
    wmask_o = '0;
    wrow_o  = '0;
    for (int j = 0; j < WIDTH; j++) begin
      wmask_o[PW'(arp_pkg::phys_pos(WIDTH, int'(slot_d), j))] = 1'b1;
      wrow_o[PW'(arp_pkg::phys_pos(WIDTH, int'(slot_d), j))]  = wdata_i[j];
    end
  end

  // slot of the word being read, aligned with the registered row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   slot_q <= '0;
    else if (en_i) slot_q <= slot_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < WIDTH; j++)
      rdata_o[j] = rrow_i[PW'(arp_pkg::phys_pos(WIDTH, int'(slot_q), j))];
  end

  // R6
  mask_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $countones(wmask_o) == WIDTH);

  generate
    if (WIDTH < arp_pkg::GROUP_W) begin : g_narrow
      // R6
      no_parity_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> (wmask_o & arp_pkg::par_mask()) == '0);
    end
  endgenerate
endmodule

// File: rtl/arp_store.sv
`timescale 1ns/1ps
module arp_store #(
  parameter int ROWS  = arp_pkg::ROWS,
  parameter int ROW_W = arp_pkg::ROW_W,
  parameter int RAW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_re_i,
  input  logic             a_we_i,
  input  logic [RAW-1:0]   a_row_i,
  input  logic [ROW_W-1:0] a_mask_i,
  input  logic [ROW_W-1:0] a_wrow_i,
  output logic [ROW_W-1:0] a_rrow_o,
  input  logic             b_re_i,
  input  logic             b_we_i,
  input  logic [RAW-1:0]   b_row_i,
  input  logic [ROW_W-1:0] b_mask_i,
  input  logic [ROW_W-1:0] b_wrow_i,
  output logic [ROW_W-1:0] b_rrow_o
);
  logic [ROW_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0] a_next, b_base, b_next;
  logic             same_row;

  // same-row writes merge; B is applied last
  assign same_row = a_we_i && b_we_i && (a_row_i == b_row_i);
  assign a_next   = (mem_q[a_row_i] & ~a_mask_i) | (a_wrow_i & a_mask_i);
  assign b_base   = same_row ? a_next : mem_q[b_row_i];
  assign b_next   = (b_base & ~b_mask_i) | (b_wrow_i & b_mask_i);

  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_row_i] <= a_next;
    if (b_we_i) mem_q[b_row_i] <= b_next;
  end

  // read-first: captures the row before this edge's writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rrow_o <= '0;
      b_rrow_o <= '0;
    end else begin
      if (a_re_i) a_rrow_o <= mem_q[a_row_i];
      if (b_re_i) b_rrow_o <= mem_q[b_row_i];
    end
  end

  // R3
  a_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_re_i |=> $stable(a_rrow_o));
  // R3
  b_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_re_i |=> $stable(b_rrow_o));
  // R7
  a_wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we_i && !same_row) |=>
      ((mem_q[$past(a_row_i)] & $past(a_mask_i)) == ($past(a_wrow_i) & $past(a_mask_i))));
  // R7
  b_wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i |=>
      ((mem_q[$past(b_row_i)] & $past(b_mask_i)) == ($past(b_wrow_i) & $past(b_mask_i))));
endmodule

// File: rtl/arp_dual_ram.sv
`timescale 1ns/1ps
module arp_dual_ram #(
  parameter bit SDP_MODE = 1'b0,
  parameter int A_WIDTH  = 4,
  parameter int B_WIDTH  = 18,
  parameter int A_AW     = $clog2(arp_pkg::depth_of(A_WIDTH)),
  parameter int B_AW     = $clog2(arp_pkg::depth_of(B_WIDTH))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_en_i,
  input  logic               a_we_i,
  input  logic [A_AW-1:0]    a_addr_i,
  input  logic [A_WIDTH-1:0] a_wdata_i,
  output logic [A_WIDTH-1:0] a_rdata_o,
  input  logic               b_en_i,
  input  logic               b_we_i,
  input  logic [B_AW-1:0]    b_addr_i,
  input  logic [B_WIDTH-1:0] b_wdata_i,
  output logic [B_WIDTH-1:0] b_rdata_o
);
  localparam int ROW_W = arp_pkg::ROW_W;
  localparam int RAW   = arp_pkg::ROW_AW;

  generate
    if (!arp_pkg::width_ok(A_WIDTH) || !arp_pkg::width_ok(B_WIDTH) ||
        (!SDP_MODE && (A_WIDTH == ROW_W || B_WIDTH == ROW_W))) begin : g_bad_cfg
      $error("arp_dual_ram: unsupported port shape");
    end
  endgenerate

  logic             a_re, a_we, b_re, b_we;
  logic [RAW-1:0]   a_row, b_row;
  logic [ROW_W-1:0] a_mask, a_wrow, a_rrow;
  logic [ROW_W-1:0] b_mask, b_wrow, b_rrow;

  assign a_re = a_en_i && !SDP_MODE;
  assign a_we = a_en_i && a_we_i;
  assign b_re = b_en_i;
  assign b_we = b_en_i && b_we_i && !SDP_MODE;

  arp_port_map #(.WIDTH(A_WIDTH), .AW(A_AW)) u_map_a (
    .clk_i, .rst_ni, .en_i(a_re), .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .rrow_i(a_rrow), .row_o(a_row), .wmask_o(a_mask), .wrow_o(a_wrow),
    .rdata_o(a_rdata_o)
  );

  arp_port_map #(.WIDTH(B_WIDTH), .AW(B_AW)) u_map_b (
    .clk_i, .rst_ni, .en_i(b_re), .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .rrow_i(b_rrow), .row_o(b_row), .wmask_o(b_mask), .wrow_o(b_wrow),
    .rdata_o(b_rdata_o)
  );

  arp_store #(.ROWS(arp_pkg::ROWS), .ROW_W(ROW_W), .RAW(RAW)) u_store (
    .clk_i, .rst_ni,
    .a_re_i(a_re), .a_we_i(a_we), .a_row_i(a_row), .a_mask_i(a_mask),
    .a_wrow_i(a_wrow), .a_rrow_o(a_rrow),
    .b_re_i(b_re), .b_we_i(b_we), .b_row_i(b_row), .b_mask_i(b_mask),
    .b_wrow_i(b_wrow), .b_rrow_o(b_rrow)
  );

  // R8
  sdp_a_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SDP_MODE |-> a_rdata_o == '0);
  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (a_rdata_o == '0 && b_rdata_o == '0));
endmodule

// File: tb/tb_arp_dual_ram.sv
`timescale 1ns/1ps
module tb_arp_dual_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // general-mode instance: 4-bit port A, 18-bit port B
  logic        a_en = 0, a_we = 0;
  logic [12:0] a_addr = '0;
  logic [3:0]  a_wd = '0, a_rd;
  logic        b_en = 0, b_we = 0;
  logic [10:0] b_addr = '0;
  logic [17:0] b_wd = '0, b_rd;

  arp_dual_ram #(.SDP_MODE(1'b0), .A_WIDTH(4), .B_WIDTH(18)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b_rd)
  );

  // split-mode instance: 72-bit write port, 9-bit read port
  logic        s_a_en = 0, s_a_we = 0;
  logic [8:0]  s_a_addr = '0;
  logic [71:0] s_a_wd = '0, s_a_rd;
  logic        s_b_en = 0, s_b_we = 0;
  logic [11:0] s_b_addr = '0;
  logic [8:0]  s_b_wd = '0, s_b_rd;

  arp_dual_ram #(.SDP_MODE(1'b1), .A_WIDTH(72), .B_WIDTH(9)) dut_sdp (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(s_a_en), .a_we_i(s_a_we), .a_addr_i(s_a_addr), .a_wdata_i(s_a_wd), .a_rdata_o(s_a_rd),
    .b_en_i(s_b_en), .b_we_i(s_b_we), .b_addr_i(s_b_addr), .b_wdata_i(s_b_wd), .b_rdata_o(s_b_rd)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        a_en, a_we;
    logic [12:0] a_addr;
    logic [3:0]  a_wd;
    logic        b_en, b_we;
    logic [10:0] b_addr;
    logic [17:0] b_wd;
    logic        ca;
    logic [3:0]  ea;
    logic        cb;
    logic [17:0] eb;
  } vec_t;

  // R6 layout: A addr a = nibble (a mod 16) of row data bits; B addr b = 18-bit slot (b mod 4)
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,13'd0,4'h0, 1'b1,1'b1,11'd0,18'h3865A, 1'b0,4'h0,1'b0,18'h0},     // B writes word 0
    '{1'b1,1'b0,13'd0,4'h0, 1'b1,1'b0,11'd0,18'h0,     1'b1,4'hA,1'b1,18'h3865A}, // R2 R6
    '{1'b1,1'b0,13'd3,4'h0, 1'b0,1'b0,11'd0,18'h0,     1'b1,4'hC,1'b1,18'h3865A}, // R6, B holds R3
    '{1'b1,1'b1,13'd1,4'h9, 1'b1,1'b0,11'd0,18'h0,     1'b1,4'h5,1'b1,18'h3865A}, // R4 R5
    '{1'b1,1'b0,13'd1,4'h0, 1'b1,1'b0,11'd0,18'h0,     1'b1,4'h9,1'b1,18'h3869A}, // merged word
    '{1'b0,1'b0,13'd0,4'h0, 1'b1,1'b1,11'd1,18'h12345, 1'b0,4'h0,1'b0,18'h0},
    '{1'b1,1'b0,13'd4,4'h0, 1'b1,1'b0,11'd1,18'h0,     1'b1,4'h5,1'b1,18'h12345},
    '{1'b1,1'b0,13'd5,4'h0, 1'b0,1'b1,11'd1,18'h0,     1'b1,4'h4,1'b1,18'h12345}, // R3 we without en
    '{1'b0,1'b0,13'd0,4'h0, 1'b1,1'b0,11'd1,18'h0,     1'b1,4'h4,1'b1,18'h12345}, // R3 no write landed
    '{1'b1,1'b1,13'd6,4'hE, 1'b0,1'b0,11'd0,18'h0,     1'b1,4'h1,1'b1,18'h12345}, // R4 narrow write
    '{1'b1,1'b0,13'd6,4'h0, 1'b1,1'b0,11'd1,18'h0,     1'b1,4'hE,1'b1,18'h13D45}, // R6 parity bit 8 kept
    '{1'b0,1'b0,13'd0,4'h0, 1'b1,1'b1,11'd1,18'h0,     1'b1,4'hE,1'b1,18'h13D45}, // R4 wide write
    '{1'b1,1'b0,13'd4,4'h0, 1'b1,1'b0,11'd1,18'h0,     1'b1,4'h0,1'b1,18'h00000}
  };

  // R7: per R6 a 4-bit word a lies inside 18-bit word a/4
  function automatic bit overlaps(logic [12:0] a, logic [10:0] b);
    return (a / 4) == 13'(b);
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(a_rd == '0 && b_rd == '0, "R1 reset A/B", {a_rd, b_rd}, 0);
    chk(s_a_rd == '0 && s_b_rd == '0, "R1 reset split", {s_a_rd[62:0], s_b_rd}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(a_rd == '0 && b_rd == '0, "R1 idle after reset", {a_rd, b_rd}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_en = VECS[i].a_en; a_we = VECS[i].a_we; a_addr = VECS[i].a_addr; a_wd = VECS[i].a_wd;
      b_en = VECS[i].b_en; b_we = VECS[i].b_we; b_addr = VECS[i].b_addr; b_wd = VECS[i].b_wd;
      @(posedge clk); #1;
      if (VECS[i].ca) chk(a_rd == VECS[i].ea, $sformatf("R2/R6 vec%0d port A", i), 72'(a_rd), 72'(VECS[i].ea));
      if (VECS[i].cb) chk(b_rd == VECS[i].eb, $sformatf("R2/R6 vec%0d port B", i), 72'(b_rd), 72'(VECS[i].eb));
    end

    // R7 write-write collision on shared nibble
    @(negedge clk);
    a_en = 1; a_we = 1; a_addr = 13'd4; a_wd = 4'h7;
    b_en = 1; b_we = 1; b_addr = 11'd1; b_wd = 18'h3FFFF;
    if (overlaps(a_addr, b_addr)) $display("NOTE collision: A addr %0d and B addr %0d share bits", a_addr, b_addr);
    @(posedge clk); #1;
    @(negedge clk);
    a_en = 1; a_we = 0; a_addr = 13'd5;
    b_en = 1; b_we = 0;
    @(posedge clk); #1;
    chk((b_rd & 18'h3FFF0) == 18'h3FFF0, "R7 non-overlap bits", 72'(b_rd & 18'h3FFF0), 72'h3FFF0);
    chk(b_rd[3:0] == 4'h7 || b_rd[3:0] == 4'hF, "R7 shared bits from a writer", 72'(b_rd[3:0]), 72'hF);
    chk(a_rd == 4'hF, "R7 A neighbour nibble", 72'(a_rd), 72'hF);
    @(negedge clk); a_en = 0; b_en = 0; a_we = 0; b_we = 0;

    // split mode: R8 R9
    @(negedge clk);
    s_a_en = 1; s_a_we = 1; s_a_addr = 9'd3;
    for (int k = 0; k < 8; k++) s_a_wd[k*9 +: 9] = 9'(9'h100 | (k * 17));
    s_b_en = 1; s_b_we = 1; s_b_addr = 12'd25; s_b_wd = 9'h0AA;
    @(posedge clk); #1;
    chk(s_a_rd == '0, "R8 A read quiet", s_a_rd, 0);
    @(negedge clk);
    s_a_en = 0; s_a_we = 1; s_a_wd = '0;
    s_b_we = 1; s_b_wd = 9'h0AA;
    for (int k = 0; k < 8; k++) begin
      s_b_addr = 12'(24 + k);
      @(posedge clk); #1;
      chk(s_b_rd == 9'(9'h100 | (k * 17)), $sformatf("R8/R9 group %0d", k), 72'(s_b_rd), 72'(9'h100 | (k * 17)));
      chk(s_a_rd == '0, "R8 A read quiet", s_a_rd, 0);
      @(negedge clk);
    end
    s_b_en = 0; s_b_we = 0; s_a_we = 0;

    // R1 reset during operation
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(b_rd == '0 && s_b_rd == '0, "R1 async clear", {b_rd, s_b_rd}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule